// File: doc/BRIEF.md
# Sequential-Address Bus Codec With Increment Line

This block is a sender and a receiver for an address bus, built as one module. Between them runs a bus of address lines plus one extra increment line. The sender keeps the last address it accepted. When a new address is exactly one more than that address, the sender leaves the address lines as they are and raises the increment line. Any other address goes onto the lines as it is, with the increment line low. The receiver keeps the last address it decoded. It adds one to that copy when the increment line is high, and otherwise takes the value on the lines.

A program that fetches from consecutive locations therefore leaves the address lines still. The only line that moves is the increment line, and it moves only when a run starts or ends. Both sides act only on cycles with a valid strobe. The bus lines are brought out so that their switching activity can be observed. An address entered on `in_addr` appears on `out_addr` two clock cycles later.

Top module: `t0_addr_codec`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `bus_addr` is 0, and `bus_inc`, `bus_vld` and `out_valid` are 0. `out_addr` is 0 after reset.
- R2: The first valid transfer after reset is always sent explicitly: `bus_inc` is 0 and `bus_addr` equals the address, even when that address is 1.
- R3: A valid address equal to the previously accepted address plus one gives `bus_inc`=1 and leaves `bus_addr` unchanged, one cycle after the input.
- R4: A valid address that is not the previous one plus one gives `bus_inc`=0 and `bus_addr` equal to that address, one cycle after the input. A repeat of the same address is sent this way.
- R5: The increment wraps modulo 2^AW, so an all-ones address followed by 0 counts as consecutive.
- R6: On a cycle with `in_valid` low, the next cycle has `bus_vld`=0 and `bus_inc`=0, and `bus_addr` is held. The sender's record of the last address is unchanged, so an address one above the last valid one is still consecutive after any number of idle cycles.
- R7: The receiver raises `out_valid` one cycle after `bus_vld`. With `bus_inc`=1 it outputs its last decoded address plus one. With `bus_inc`=0 it outputs `bus_addr`.
- R8: Every valid input address reappears exactly on `out_addr`, with `out_valid`=1, two cycles after it was presented.
- R9: During an unbroken run of consecutive valid addresses, from the second increment beat onward, no line among `bus_addr` and `bus_inc` changes between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | New address offered to the sender this cycle |
| in_addr | input | AW | Address offered to the sender |
| bus_addr | output | AW | Address lines of the encoded bus |
| bus_inc | output | 1 | Increment line of the encoded bus |
| bus_vld | output | 1 | Bus carries a transfer this cycle |
| out_valid | output | 1 | Decoded address is valid this cycle |
| out_addr | output | AW | Decoded address at the receiver |

## Verification
The bench goes after the first transfer after reset. A sender that treats the reset value as a real previous address would send address 1 as an increment. Wrap from all-ones to zero is tested, and a sender that compares without the modulo wrap would toggle every line there. Repeated identical addresses and idle gaps inside a sequential run are covered as well. A sender that updated its state on idle cycles, or left the increment line high while idle, would break the stream, and the receiver would then add one twice or lose its place. A long sequential burst is scored by counting line transitions, and any count above zero exposes a sender that redrives the lines.

// File: rtl/t0_addr_codec.sv
module t0_addr_codec #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  output logic [AW-1:0] bus_addr,
  output logic          bus_inc,
  output logic          bus_vld,
  output logic          out_valid,
  output logic [AW-1:0] out_addr
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] tx_last;
  logic          tx_primed;
  logic [AW-1:0] tx_next;
  logic          tx_seq;
  logic [AW-1:0] rx_next;

  assign tx_next = tx_last + ONE;
  assign tx_seq  = tx_primed && (in_addr == tx_next);
  assign rx_next = out_addr + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_last   <= '0;
      tx_primed <= 1'b0;
      bus_addr  <= '0;
      bus_inc   <= 1'b0;
      bus_vld   <= 1'b0;
    end else begin
      bus_vld <= in_valid;
      bus_inc <= in_valid && tx_seq;
      if (in_valid) begin
        tx_last   <= in_addr;
        tx_primed <= 1'b1;
        if (!tx_seq) bus_addr <= in_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= bus_vld;
      if (bus_vld) out_addr <= bus_inc ? rx_next : bus_addr;
    end
  end

  assert_first_explicit_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!tx_primed) && $past(in_valid)) |-> (bus_vld && !bus_inc && bus_addr == $past(in_addr)));

  assert_inc_freezes_lines_R3: assert property (@(posedge clk) disable iff (rst)
    bus_inc |-> (bus_vld && $stable(bus_addr)));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_vld |-> (!bus_inc && $stable(bus_addr)));

  assert_rx_increment_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(bus_inc)) |-> (out_addr == $past(out_addr) + ONE));

  assert_rx_explicit_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(bus_inc)) |-> (out_addr == $past(bus_addr)));

  assert_roundtrip_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_addr == $past(in_addr, 2)));

endmodule

// File: tb/t0_addr_codec_tb.sv
module t0_addr_codec_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [AW-1:0] bus_addr;
  logic          bus_inc;
  logic          bus_vld;
  logic          out_valid;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_last;
  logic          m_primed;
  logic [AW-1:0] m_bus;
  logic          d1_v;
  logic [AW-1:0] d1_a;
  logic [AW:0]   prev_lines;
  int            toggles;

  always #5 clk = ~clk;

  t0_addr_codec #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .bus_addr(bus_addr), .bus_inc(bus_inc), .bus_vld(bus_vld),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_last = '0; m_primed = 1'b0; m_bus = '0; d1_v = 1'b0; d1_a = '0;
    prev_lines = '0; toggles = 0;
  endtask

  task automatic step(input logic v, input logic [AW-1:0] a, input string req);
    logic seq;
    logic exp_inc;
    logic [AW:0] now;
    seq = v && m_primed && (a == m_last + AW'(1));
    exp_inc = seq;
    if (v) begin
      if (!seq) m_bus = a;
      m_last = a;
      m_primed = 1'b1;
    end
    in_valid = v;
    in_addr = a;
    @(negedge clk);
    chk(req, "bus_vld", AW'(bus_vld), AW'(v));
    chk(req, "bus_inc", AW'(bus_inc), AW'(exp_inc));
    chk(req, "bus_addr", bus_addr, m_bus);
    chk("R7", "out_valid", AW'(out_valid), AW'(d1_v));
    if (d1_v) chk("R8", "out_addr", out_addr, d1_a);
    now = {bus_inc, bus_addr};
    toggles += $countones(now ^ prev_lines);
    prev_lines = now;
    d1_v = v;
    d1_a = a;
  endtask

  task automatic flush();
    step(1'b0, in_addr, "R6");
    step(1'b0, in_addr, "R6");
  endtask

  task automatic t_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "bus_addr", bus_addr, '0);
    chk("R1", "bus_inc", AW'(bus_inc), '0);
    chk("R1", "bus_vld", AW'(bus_vld), '0);
    chk("R1", "out_valid", AW'(out_valid), '0);
    chk("R1", "out_addr", out_addr, '0);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1", "bus_vld after release", AW'(bus_vld), '0);
    chk("R1", "out_valid after release", AW'(out_valid), '0);
  endtask

  task automatic t_first_explicit();
    t_reset();
    step(1'b1, 16'h0001, "R2");
    step(1'b1, 16'h0002, "R3");
    flush();
  endtask

  task automatic t_seq_burst();
    logic [AW-1:0] base;
    t_reset();
    base = 16'h3A00;
    step(1'b1, base, "R4");
    step(1'b1, base + 16'd1, "R3");
    toggles = 0;
    for (int i = 2; i < 60; i++) step(1'b1, base + AW'(i), "R3");
    chk("R9", "toggles in sequential run", AW'(toggles), '0);
    flush();
  endtask

  task automatic t_jumps();
    t_reset();
    step(1'b1, 16'h1000, "R2");
    step(1'b1, 16'h1001, "R3");
    step(1'b1, 16'h2000, "R4");
    step(1'b1, 16'h1FFF, "R4");
    step(1'b1, 16'h1FFF, "R4");
    step(1'b1, 16'h2000, "R3");
    step(1'b1, 16'h2002, "R4");
    step(1'b1, 16'h2003, "R3");
    flush();
  endtask

  task automatic t_wrap();
    t_reset();
    step(1'b1, 16'hFFFE, "R2");
    step(1'b1, 16'hFFFF, "R3");
    step(1'b1, 16'h0000, "R5");
    step(1'b1, 16'h0001, "R5");
    flush();
  endtask

  task automatic t_idle_gaps();
    t_reset();
    step(1'b1, 16'h0400, "R2");
    step(1'b1, 16'h0401, "R3");
    step(1'b0, 16'h0999, "R6");
    step(1'b0, 16'h0402, "R6");
    step(1'b0, 16'hFFFF, "R6");
    step(1'b1, 16'h0402, "R6");
    step(1'b0, 16'h0000, "R6");
    step(1'b1, 16'h0403, "R6");
    step(1'b1, 16'h0404, "R3");
    flush();
  endtask

  initial begin
    model_reset();
    t_first_explicit();
    t_seq_burst();
    t_jumps();
    t_wrap();
    t_idle_gaps();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule